// File: doc/BRIEF.md
# NAND Flash Access Timing Sequencer

This block runs one read or write cycle on an 8-bit multiplexed NAND Flash bus. The host raises a request with a direction, a two-bit latch-select code, a write byte and four 8-bit timing fields. The access then steps through four phases, each with its own length in clock cycles. In the setup phase the chip is selected and the latch enables are valid. In the strobe phase read enable or write enable is low. In the hold phase the chip stays selected with address and data stable. On writes there is also a bus-turnaround window, during which the shared data bus stays undriven after the access starts.

The latch-select code picks the kind of bus cycle: a plain data cycle, a command cycle or an address cycle. Commands, address bytes and data all travel over the same byte-wide bus. The host sends each byte as its own access, so it can issue as many address bytes as the memory needs. A ready/busy input from the memory stretches the strobe phase. The block reports the end of each access with a one-clock done pulse, and it presents the byte captured on a read.

Top module: `nand_access_seq`

## Requirements
- R1: After reset the block is idle. `chipSelN`, `readEnN` and `writeEnN` are high, `busOutEn` and `done` are low, and `reqReady` is high.
- R2: The setup phase runs from the first cycle with `chipSelN` low until the strobe asserts. It lasts `cfgSetup`+1 cycles, a range of 1 to 256.
- R3: When the memory reports ready, the strobe stays low for `cfgWait`+1 cycles, clamped to the range 2 to 255.
- R4: The hold phase lasts `cfgHold`+1 cycles, clamped to 1 to 254. `done` is high for exactly one cycle, the last hold cycle, and `chipSelN` is high in the next cycle.
- R5: On a write, `busOutEn` stays low for the first `cfgHiz`+1 cycles of the access, clamped to 1 to 255, and is high from then on while the chip is selected. On a read, `busOutEn` never rises.
- R6: Throughout an access, `addrLatchEn` equals `reqSel[1]` (host address bit 17) and `cmdLatchEn` equals `reqSel[0]` (host address bit 16), as both stood when the request was accepted.
- R7: `reqWrite`=1 selects a write, which pulses only `writeEnN`. `reqWrite`=0 selects a read, which pulses only `readEnN`. The two strobes are never low together.
- R8: `rdData` takes the value of `busIn` at the clock edge where `readEnN` returns high. It keeps that value after the access ends.
- R9: While `readyBusy` is low (busy), the strobe cannot end. The strobe ends at the first edge where the minimum count of R3 is met and `readyBusy` is high, so its length is the larger of the two.
- R10: A request is accepted only when `reqReady` is high, and `reqReady` is high only while idle. A request presented during an access starts no access and changes none of the current access's outputs.
- R11: Whenever `busOutEn` is high, `busOut` carries the write byte captured with the request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Host request strobe, taken when reqReady is high |
| reqWrite | input | 1 | 1 = write access, 0 = read access |
| reqSel | input | 2 | Host address bits 17:16; bit 1 drives address latch enable, bit 0 command latch enable |
| reqWrData | input | DATA_W | Byte to write (command, address or data) |
| cfgSetup | input | 8 | Setup length field |
| cfgWait | input | 8 | Minimum strobe length field |
| cfgHold | input | 8 | Hold length field |
| cfgHiz | input | 8 | Write bus-turnaround length field |
| reqReady | output | 1 | Block idle and able to take a request |
| chipSelN | output | 1 | Active-low chip select |
| readEnN | output | 1 | Active-low read strobe |
| writeEnN | output | 1 | Active-low write strobe |
| addrLatchEn | output | 1 | Address latch enable |
| cmdLatchEn | output | 1 | Command latch enable |
| busOut | output | DATA_W | Byte driven onto the shared bus |
| busOutEn | output | 1 | Tri-state enable for busOut |
| busIn | input | DATA_W | Byte read from the shared bus |
| readyBusy | input | 1 | Memory ready (1) or busy (0) |
| rdData | output | DATA_W | Byte captured on the last read |
| done | output | 1 | One-cycle pulse in the last hold cycle |

## Verification
Two events can fall in the same cycle: the memory's ready/busy line returning to ready, and the strobe reaching its minimum count. The bench holds `readyBusy` low for a set number of strobe cycles. It sets that number equal to the minimum, above it and below it, and expects the strobe length to be the larger of the two. A second overlap comes from presenting a new request in the middle of an access, including its last cycle. The scoreboard then accepts exactly one access and sees unchanged latch enables and bus data.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  localparam int TIME_W = 8;
  localparam int CNT_W  = TIME_W + 1;

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_CMD, PH_HOLD} phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // request accepted this cycle
    logic active;   // chip selected
    logic cmdOn;    // read/write strobe phase
    logic capture;  // last strobe cycle
    logic finish;   // last hold cycle
  } seqStrobes_t;

  function automatic logic [CNT_W-1:0] clampCycles(input logic [TIME_W-1:0] field,
                                                   input int lo, input int hi);
    int v;
    v = int'(field) + 1;
    if (v < lo) v = lo;
    if (v > hi) v = hi;
    return CNT_W'(v);
  endfunction
endpackage

// File: rtl/nand_seq_ctrl.sv
module nand_seq_ctrl
  import nand_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             readyBusy,
  input  logic [CNT_W-1:0] setupCycles,
  input  logic [CNT_W-1:0] waitCycles,
  input  logic [CNT_W-1:0] holdCycles,
  output seqStrobes_t      strobes,
  output logic             reqReady
);
  phase_t           phase;
  logic [CNT_W-1:0] cnt;
  logic             cmdDone;

  assign cmdDone = (phase == PH_CMD) && (cnt >= waitCycles) && readyBusy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (reqValid) begin
          phase <= PH_SETUP;
          cnt   <= CNT_W'(1);
        end
        PH_SETUP: if (cnt == setupCycles) begin
          phase <= PH_CMD;
          cnt   <= CNT_W'(1);
        end else begin
          cnt <= cnt + 1'b1;
        end
        PH_CMD: if (cmdDone) begin
          phase <= PH_HOLD;
          cnt   <= CNT_W'(1);
        end else if (cnt < waitCycles) begin
          cnt <= cnt + 1'b1;
        end
        PH_HOLD: if (cnt == holdCycles) begin
          phase <= PH_IDLE;
          cnt   <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.load    = (phase == PH_IDLE) && reqValid;
    strobes.active  = (phase != PH_IDLE);
    strobes.cmdOn   = (phase == PH_CMD);
    strobes.capture = cmdDone;
    strobes.finish  = (phase == PH_HOLD) && (cnt == holdCycles);
  end

  assign reqReady = (phase == PH_IDLE);
endmodule

// File: rtl/nand_seq_datapath.sv
module nand_seq_datapath
  import nand_seq_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int SETUP_MIN = 1,
  parameter int SETUP_MAX = 256,
  parameter int WAIT_MIN  = 2,
  parameter int WAIT_MAX  = 255,
  parameter int HOLD_MIN  = 1,
  parameter int HOLD_MAX  = 254,
  parameter int HIZ_MIN   = 1,
  parameter int HIZ_MAX   = 255
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       strobes,
  input  logic              reqWrite,
  input  logic [1:0]        reqSel,
  input  logic [DATA_W-1:0] reqWrData,
  input  logic [TIME_W-1:0] cfgSetup,
  input  logic [TIME_W-1:0] cfgWait,
  input  logic [TIME_W-1:0] cfgHold,
  input  logic [TIME_W-1:0] cfgHiz,
  input  logic [DATA_W-1:0] busIn,
  output logic [CNT_W-1:0]  setupCycles,
  output logic [CNT_W-1:0]  waitCycles,
  output logic [CNT_W-1:0]  holdCycles,
  output logic              chipSelN,
  output logic              readEnN,
  output logic              writeEnN,
  output logic              addrLatchEn,
  output logic              cmdLatchEn,
  output logic [DATA_W-1:0] busOut,
  output logic              busOutEn,
  output logic [DATA_W-1:0] rdData
);
  localparam int SEL_ALE = 1;
  localparam int SEL_CLE = 0;

  logic              isWrite;
  logic [1:0]        selHold;
  logic [DATA_W-1:0] dataHold;
  logic [CNT_W-1:0]  hizLeft;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      isWrite     <= 1'b0;
      selHold     <= '0;
      dataHold    <= '0;
      setupCycles <= CNT_W'(SETUP_MIN);
      waitCycles  <= CNT_W'(WAIT_MIN);
      holdCycles  <= CNT_W'(HOLD_MIN);
      hizLeft     <= '0;
      rdData      <= '0;
    end else begin
      if (strobes.load) begin
        isWrite     <= reqWrite;
        selHold     <= reqSel;
        dataHold    <= reqWrData;
        setupCycles <= clampCycles(cfgSetup, SETUP_MIN, SETUP_MAX);
        waitCycles  <= clampCycles(cfgWait, WAIT_MIN, WAIT_MAX);
        holdCycles  <= clampCycles(cfgHold, HOLD_MIN, HOLD_MAX);
        hizLeft     <= clampCycles(cfgHiz, HIZ_MIN, HIZ_MAX);
      end else if (strobes.active && (hizLeft != '0)) begin
        hizLeft <= hizLeft - 1'b1;
      end
      if (strobes.capture && !isWrite) rdData <= busIn;
    end
  end

  assign chipSelN    = !strobes.active;
  assign readEnN     = !(strobes.cmdOn && !isWrite);
  assign writeEnN    = !(strobes.cmdOn && isWrite);
  assign addrLatchEn = strobes.active && selHold[SEL_ALE];
  assign cmdLatchEn  = strobes.active && selHold[SEL_CLE];
  assign busOut      = dataHold;
  assign busOutEn    = strobes.active && isWrite && (hizLeft == '0);
endmodule

// File: rtl/nand_access_seq.sv
module nand_access_seq
  import nand_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [1:0]        reqSel,
  input  logic [DATA_W-1:0] reqWrData,
  input  logic [7:0]        cfgSetup,
  input  logic [7:0]        cfgWait,
  input  logic [7:0]        cfgHold,
  input  logic [7:0]        cfgHiz,
  output logic              reqReady,
  output logic              chipSelN,
  output logic              readEnN,
  output logic              writeEnN,
  output logic              addrLatchEn,
  output logic              cmdLatchEn,
  output logic [DATA_W-1:0] busOut,
  output logic              busOutEn,
  input  logic [DATA_W-1:0] busIn,
  input  logic              readyBusy,
  output logic [DATA_W-1:0] rdData,
  output logic              done
);
  seqStrobes_t      strobes;
  logic [CNT_W-1:0] setupCycles, waitCycles, holdCycles;

  nand_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .readyBusy(readyBusy),
    .setupCycles(setupCycles), .waitCycles(waitCycles), .holdCycles(holdCycles),
    .strobes(strobes), .reqReady(reqReady)
  );

  nand_seq_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .reqWrite(reqWrite), .reqSel(reqSel), .reqWrData(reqWrData),
    .cfgSetup(cfgSetup), .cfgWait(cfgWait), .cfgHold(cfgHold), .cfgHiz(cfgHiz),
    .busIn(busIn),
    .setupCycles(setupCycles), .waitCycles(waitCycles), .holdCycles(holdCycles),
    .chipSelN(chipSelN), .readEnN(readEnN), .writeEnN(writeEnN),
    .addrLatchEn(addrLatchEn), .cmdLatchEn(cmdLatchEn),
    .busOut(busOut), .busOutEn(busOutEn), .rdData(rdData)
  );

  assign done = strobes.finish;
endmodule

// File: rtl/nand_access_seq_chk.sv
module nand_access_seq_chk (
  input logic clk,
  input logic rstN,
  input logic reqReady,
  input logic chipSelN,
  input logic readEnN,
  input logic writeEnN,
  input logic addrLatchEn,
  input logic cmdLatchEn,
  input logic busOutEn,
  input logic readyBusy,
  input logic done
);
  // R7
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!readEnN && !writeEnN));

  // R7
  strobe_in_select_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!readEnN || !writeEnN) |-> !chipSelN);

  // R4
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R4
  done_then_deselect_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> chipSelN);

  // R6
  latch_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!chipSelN && !$past(chipSelN)) |-> ($stable(addrLatchEn) && $stable(cmdLatchEn)));

  // R5
  no_drive_on_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busOutEn && !readEnN));

  // R5
  drive_in_select_chk: assert property (@(posedge clk) disable iff (!rstN)
    busOutEn |-> !chipSelN);

  // R9
  busy_stretch_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((!readEnN || !writeEnN) && !readyBusy) |=> (!readEnN || !writeEnN));

  // R10
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> chipSelN);
endmodule

bind nand_access_seq nand_access_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .chipSelN(chipSelN),
  .readEnN(readEnN), .writeEnN(writeEnN), .addrLatchEn(addrLatchEn),
  .cmdLatchEn(cmdLatchEn), .busOutEn(busOutEn), .readyBusy(readyBusy), .done(done)
);

// File: tb/nand_access_seq_bench.sv
module nand_access_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [1:0] reqSel = '0;
  logic [7:0] reqWrData = '0, cfgSetup = '0, cfgWait = '0, cfgHold = '0, cfgHiz = '0;
  logic reqReady, chipSelN, readEnN, writeEnN, addrLatchEn, cmdLatchEn, busOutEn, done;
  logic [7:0] busOut, rdData;
  logic [7:0] busIn = '0;
  logic readyBusy = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_access_seq u_nand_access_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite), .reqSel(reqSel),
    .reqWrData(reqWrData), .cfgSetup(cfgSetup), .cfgWait(cfgWait), .cfgHold(cfgHold),
    .cfgHiz(cfgHiz), .reqReady(reqReady), .chipSelN(chipSelN), .readEnN(readEnN),
    .writeEnN(writeEnN), .addrLatchEn(addrLatchEn), .cmdLatchEn(cmdLatchEn),
    .busOut(busOut), .busOutEn(busOutEn), .busIn(busIn), .readyBusy(readyBusy),
    .rdData(rdData), .done(done)
  );

  typedef struct {
    bit wr; bit ale; bit cle;
    int s; int w; int h; int z;
    logic [7:0] data; logic [7:0] rd;
  } exp_t;

  exp_t expQ[$];
  int compared = 0, mismatched = 0;
  int busyLen = 0;
  logic [7:0] rdVal = '0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int clampI(input int f, input int lo, input int hi);
    int v = f + 1;
    if (v < lo) v = lo;
    if (v > hi) v = hi;
    return v;
  endfunction

  // driver: push the expected item, then present the request
  task automatic doAccess(input bit wr, input logic [1:0] sel, input logic [7:0] data,
                          input int s, input int w, input int h, input int z,
                          input int busy, input logic [7:0] rd);
    exp_t e;
    int wc;
    while (!reqReady) @(negedge clk);
    wc = clampI(w, 2, 255);
    e.wr = wr; e.ale = sel[1]; e.cle = sel[0];
    e.s = clampI(s, 1, 256);
    e.w = (busy > wc) ? busy : wc;
    e.h = clampI(h, 1, 254);
    e.z = clampI(z, 1, 255);
    e.data = data; e.rd = rd;
    expQ.push_back(e);
    busyLen = busy; rdVal = rd;
    reqValid = 1'b1; reqWrite = wr; reqSel = sel; reqWrData = data;
    cfgSetup = s[7:0]; cfgWait = w[7:0]; cfgHold = h[7:0]; cfgHiz = z[7:0];
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (!chipSelN || expQ.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor plus memory model
  bit inAcc = 0, drove, dataBad, latchBad, readyBad, dirBad;
  int setupN, strobeN, holdN, hizN, doneN, doneAt, strobeSeen = 0;
  exp_t cur;

  always @(negedge clk) begin
    if (rstN && !chipSelN) begin
      if (!inAcc) begin
        inAcc = 1; drove = 0; dataBad = 0; latchBad = 0; readyBad = 0; dirBad = 0;
        setupN = 0; strobeN = 0; holdN = 0; hizN = 0; doneN = 0; doneAt = -1;
        if (expQ.size() == 0) begin
          check(0, "R10 unexpected access", 1, 0);
          cur = '{default: 0};
        end else cur = expQ.pop_front();
      end
      if (!readEnN || !writeEnN) strobeN++;
      else if (strobeN == 0) setupN++;
      else holdN++;
      if (busOutEn) begin
        drove = 1;
        if (busOut !== cur.data) dataBad = 1;
      end else if (!drove) hizN++;
      if (addrLatchEn !== cur.ale || cmdLatchEn !== cur.cle) latchBad = 1;
      if (reqReady) readyBad = 1;
      if ((!writeEnN && !cur.wr) || (!readEnN && cur.wr)) dirBad = 1;
      if (done) begin doneN++; doneAt = holdN; end
    end else if (rstN && inAcc) begin
      inAcc = 0;
      check(setupN == cur.s, "R2 setup length", setupN, cur.s);
      check(strobeN == cur.w, "R3/R9 strobe length", strobeN, cur.w);
      check(holdN == cur.h, "R4 hold length", holdN, cur.h);
      check(doneN == 1 && doneAt == cur.h, "R4 done position", doneAt, cur.h);
      check(!latchBad, "R6 latch enables", latchBad, 0);
      check(!dirBad, "R7 strobe direction", dirBad, 0);
      check(!readyBad, "R10 ready during access", readyBad, 0);
      if (cur.wr) begin
        check(drove && hizN == cur.z, "R5 turnaround length", hizN, cur.z);
        check(!dataBad, "R11 write byte", dataBad, 0);
      end else begin
        check(!drove, "R5 no drive on read", drove, 0);
        check(rdData === cur.rd, "R8 read capture", rdData, cur.rd);
      end
    end
    // memory model: busy for busyLen strobe cycles, read byte valid only under strobe
    if (!readEnN || !writeEnN) begin
      strobeSeen++;
      readyBusy = (strobeSeen >= busyLen);
      busIn = rdVal;
    end else begin
      strobeSeen = 0;
      readyBusy = 1'b1;
      busIn = ~rdVal;
    end
  end

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(chipSelN && readEnN && writeEnN, "R1 strobes high", {chipSelN, readEnN, writeEnN}, 7);
        check(!busOutEn && !done, "R1 bus and done low", {busOutEn, done}, 0);
        check(reqReady, "R1 ready", reqReady, 1);
        rstN = 1'b1;
        @(negedge clk);
        doAccess(1, 2'b00, 8'hA5, 0, 0, 0, 0, 0, 8'h00);     // minimum lengths
        waitIdle();
        doAccess(0, 2'b01, 8'h00, 3, 4, 2, 0, 0, 8'h3C);     // command-latch read
        waitIdle();
        doAccess(1, 2'b10, 8'h5A, 2, 3, 5, 9, 0, 8'h00);     // turnaround into hold
        waitIdle();
        doAccess(0, 2'b00, 8'h00, 255, 255, 255, 0, 0, 8'hC3); // upper clamps
        waitIdle();
        doAccess(1, 2'b00, 8'h81, 0, 1, 253, 255, 0, 8'h00); // hold/turnaround clamps
        waitIdle();
        doAccess(0, 2'b00, 8'h00, 1, 2, 1, 0, 7, 8'h96);     // R9 busy longer
        waitIdle();
        doAccess(1, 2'b01, 8'h70, 1, 4, 1, 0, 5, 8'h00);     // R9 busy ends with minimum
        waitIdle();
        doAccess(0, 2'b10, 8'h00, 0, 5, 0, 0, 2, 8'h69);     // R9 busy shorter
        waitIdle();
        // R10: requests during an access are ignored
        fork
          doAccess(1, 2'b10, 8'hE7, 9, 3, 3, 2, 0, 8'h00);
          begin
            @(negedge clk);
            while (chipSelN) @(negedge clk);
            @(negedge clk);
            reqValid = 1'b1; reqWrite = 1'b0; reqSel = 2'b01; reqWrData = 8'h11;
            cfgSetup = 8'd0; cfgHiz = 8'd0;
            check(!reqReady, "R10 busy not ready", reqReady, 0);
            while (!done) @(negedge clk);
            reqValid = 1'b0;
          end
        join
        waitIdle();
        repeat (5) @(negedge clk);
        check(chipSelN, "R10 no extra access", chipSelN, 1);
        doAccess(0, 2'b11, 8'h00, 0, 0, 0, 0, 0, 8'h2D);     // back to back
        doAccess(1, 2'b00, 8'h44, 0, 0, 0, 1, 0, 8'h00);
        waitIdle();
        check(expQ.size() == 0, "R10 all accesses seen", expQ.size(), 0);
      end
      begin
        repeat (WATCHDOG) @(posedge clk);
        check(0, "watchdog expired", 0, 1);
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule